// File: doc/BRIEF.md
# Receive End-of-Message Detector

This block sits between the bit-serial output of a radio demodulator and a host controller. It decides in hardware when an incoming packet has ended, so that the receiver power-enable can be dropped at once, without waiting for software. The host arms the block with a receive-enable pulse. The block then raises the receiver power-enable and starts an idle timer. When the demodulator flags a start of message, the block assembles the following bits into bytes and watches them for the end of the message. It then drops the power-enable on the same clock edge that samples the last bit.

There are two end-detection modes. In length mode, a one-byte length field sits at a programmable byte offset within the packet, and the message ends after offset+1+length bytes. In character mode, a programmable terminator byte ends the message. A programmable escape byte makes the byte that follows it literal. If no message starts within the programmed idle interval, the power-enable falls on its own. A held two-bit status tells the host whether the run completed normally or timed out. The host sets the configuration through a small write port, and the values are taken into use at the next receive-enable.

The demodulator's bit clock is presented as a bit strobe that is synchronous to the system clock.

Top module: `rx_eom_detect`

## Requirements
- R1: After reset, rx_pwr_en is 0 and status is 2'b00. The configuration resets to length mode, offset 0, terminator 0xFE, escape 0x80 and an idle limit of TMO_RST cycles.
- R2: A host_rx_en pulse makes rx_pwr_en 1 from the next cycle, restarts the idle timer and loads the written configuration. Writes made during a run have no effect until the next host_rx_en.
- R3: Bits are taken only while a message is in progress, which is after a som strobe seen while waiting. Each sampled bit_data on a bit_stb is shifted in most significant bit first, and every eight bits form one byte.
- R4: In length mode, the byte at zero-based index offset is the length L. rx_pwr_en falls on the clock edge that samples the last bit of byte number offset+1+L, and status becomes 2'b01.
- R5: In character mode, a received byte equal to the terminator ends the message in the same way as R4.
- R6: In character mode, the byte that follows an escape byte is literal and never ends the message. This holds also when that byte is another escape byte. The escape test is made before the terminator test.
- R7: If no som arrives while waiting, rx_pwr_en stays high for exactly max(T,1) cycles after the host_rx_en edge, where T is the idle limit. It then falls and status becomes 2'b10.
- R8: A som sampled on the same edge on which the idle limit would expire starts the message, and no timeout is reported.
- R9: A nonzero status is held until a status_clr pulse clears it to 2'b00. When a clear and a new completion fall on the same edge, the completion wins.
- R10: Write addresses are as follows: 0 holds the mode in bit 0 (1 selects character mode), 1 the offset, 2 the terminator, 3 the escape, 4 the idle limit low byte and 5 the idle limit high byte. Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration write address |
| cfg_wdata | input | 8 | Configuration write data |
| host_rx_en | input | 1 | Re-arm pulse from the host |
| status_clr | input | 1 | Clears the held status |
| som | input | 1 | Start-of-message strobe from the demodulator |
| bit_stb | input | 1 | Receive bit strobe (demodulator bit clock) |
| bit_data | input | 1 | Serial receive data |
| rx_pwr_en | output | 1 | Receiver power-enable |
| status | output | 2 | 00 idle, 01 completed, 10 timed out |

## Verification
Two pairs of functions can land on the same edge. The first pair is the idle timer expiring and the start-of-message strobe arriving. The bench places som exactly on the expiry edge, where the power must stay on with no timeout reported, and then one cycle later, where the timeout must already have occurred. The second pair is the host clearing the status and the final bit completing a message. The bench drives status_clr together with the last bit of a terminator and expects the completed code to remain. Length mode is swept over several offsets and lengths, and the expected power state after every byte is computed from offset+1+L.

// File: rtl/rx_eom_pkg.sv
package rx_eom_pkg;
    localparam int BYTE_W = 8;
    localparam int TMO_W  = 16;
    localparam int IDX_W  = BYTE_W + 1;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
    localparam logic [ADDR_W-1:0] A_OFFSET = 3'd1;
    localparam logic [ADDR_W-1:0] A_TERM   = 3'd2;
    localparam logic [ADDR_W-1:0] A_ESC    = 3'd3;
    localparam logic [ADDR_W-1:0] A_TMO_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_TMO_HI = 3'd5;

    typedef enum logic [1:0] {ST_OFF, ST_WAIT, ST_RECV} rx_state_e;
    typedef enum logic [1:0] {STS_NONE = 2'b00, STS_DONE = 2'b01, STS_TMO = 2'b10} rx_sts_e;

    typedef struct packed {
        logic              chr_mode;
        logic [BYTE_W-1:0] offset;
        logic [BYTE_W-1:0] term;
        logic [BYTE_W-1:0] esc;
        logic [TMO_W-1:0]  tmo;
    } rx_cfg_t;

    function automatic logic len_reached(input logic [IDX_W-1:0] idx,
                                         input logic [BYTE_W-1:0] off,
                                         input logic [BYTE_W-1:0] len);
        return idx == ({1'b0, off} + {1'b0, len});
    endfunction
endpackage

// File: rtl/rx_eom_cfg.sv
module rx_eom_cfg
    import rx_eom_pkg::*;
#(
    parameter logic [TMO_W-1:0] TMO_RST = 16'd200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              load,
    output rx_cfg_t           act
);
    rx_cfg_t shd;
    localparam rx_cfg_t CFG_RST = '{chr_mode: 1'b0, offset: 8'h00, term: 8'hFE,
                                    esc: 8'h80, tmo: TMO_RST};

    always_ff @(posedge clk) begin
        if (rst) begin
            shd <= CFG_RST;
        end else if (we) begin
            case (addr)
                A_MODE:   shd.chr_mode <= wdata[0];
                A_OFFSET: shd.offset   <= wdata;
                A_TERM:   shd.term     <= wdata;
                A_ESC:    shd.esc      <= wdata;
                A_TMO_LO: shd.tmo[BYTE_W-1:0]     <= wdata;
                A_TMO_HI: shd.tmo[TMO_W-1:BYTE_W] <= wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       act <= CFG_RST;
        else if (load) act <= shd;
    end

    // R2: the active set is the written set captured at the re-arm
    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (act == $past(shd)));
    // R2: between re-arms the active set does not move
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(act));
endmodule

// File: rtl/rx_eom_deser.sv
module rx_eom_deser
    import rx_eom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              en,
    input  logic              bit_stb,
    input  logic              bit_data,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int BC_W = $clog2(BYTE_W);
    logic [BYTE_W-2:0] sh;
    logic [BC_W-1:0]   bcnt;

    assign byte_vld = en && bit_stb && (bcnt == BC_W'(BYTE_W - 1));
    assign byte_val = {sh, bit_data};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh   <= '0;
            bcnt <= '0;
        end else if (en && bit_stb) begin
            sh   <= {sh[BYTE_W-3:0], bit_data};
            bcnt <= bcnt + 1'b1;
        end
    end

    // R3: a new message always starts on a byte boundary
    assert_bit_align_R3: assert property (@(posedge clk) disable iff (rst)
        clear |=> (bcnt == '0));
    // R3: no bit is taken while disabled
    assert_no_bits_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!en && !clear) |=> $stable(bcnt));
endmodule

// File: rtl/rx_eom_end_det.sv
module rx_eom_end_det
    import rx_eom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              chr_mode,
    input  logic [BYTE_W-1:0] offset,
    input  logic [BYTE_W-1:0] term,
    input  logic [BYTE_W-1:0] esc,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_val,
    output logic              eom
);
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] len;
    logic              esc_pend;
    logic              at_len, past_len;

    assign at_len   = (idx == {1'b0, offset});
    assign past_len = (idx > {1'b0, offset});

    always_comb begin
        eom = 1'b0;
        if (byte_vld) begin
            if (chr_mode)
                eom = !esc_pend && (byte_val != esc) && (byte_val == term);
            else if (at_len)
                eom = (byte_val == '0);
            else if (past_len)
                eom = len_reached(idx, offset, len);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx      <= '0;
            len      <= '0;
            esc_pend <= 1'b0;
        end else if (byte_vld) begin
            idx <= idx + 1'b1;
            if (at_len) len <= byte_val;
            esc_pend <= chr_mode && !esc_pend && (byte_val == esc);
        end
    end

    // R6: a byte behind an escape never closes the message
    assert_esc_literal_R6: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && chr_mode && esc_pend) |-> !eom);
    // R4: in length mode nothing ends before the length field
    assert_no_early_end_R4: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && !chr_mode && (idx < {1'b0, offset})) |-> !eom);
endmodule

// File: rtl/rx_eom_idle_tmr.sv
module rx_eom_idle_tmr
    import rx_eom_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [TMO_W-1:0] cnt;
    logic [TMO_W:0]   lim1;

    assign lim1   = (limit == '0) ? (TMO_W+1)'(1) : {1'b0, limit};
    assign expire = run && (({1'b0, cnt} + 1'b1) >= lim1);

    always_ff @(posedge clk) begin
        if (rst || restart)      cnt <= '0;
        else if (run && !expire) cnt <= cnt + 1'b1;
    end

    // R7: the count never passes the programmed interval
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (run && !restart) |-> ({1'b0, cnt} < lim1));
endmodule

// File: rtl/rx_eom_detect.sv
module rx_eom_detect
    import rx_eom_pkg::*;
#(
    parameter logic [TMO_W-1:0] TMO_RST = 16'd200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              host_rx_en,
    input  logic              status_clr,
    input  logic              som,
    input  logic              bit_stb,
    input  logic              bit_data,
    output logic              rx_pwr_en,
    output logic [1:0]        status
);
    rx_state_e         state;
    rx_sts_e           sts;
    rx_cfg_t           cfg;
    logic              expire, byte_vld, eom;
    logic [BYTE_W-1:0] byte_val;
    logic              start_evt, tmo_evt, eom_evt;

    assign start_evt = (state == ST_WAIT) && som && !host_rx_en;
    assign tmo_evt   = (state == ST_WAIT) && expire && !som && !host_rx_en;
    assign eom_evt   = (state == ST_RECV) && eom && !host_rx_en;

    rx_eom_cfg #(.TMO_RST(TMO_RST)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .load(host_rx_en), .act(cfg));

    rx_eom_idle_tmr u_tmr (
        .clk(clk), .rst(rst), .restart(host_rx_en), .run(state == ST_WAIT),
        .limit(cfg.tmo), .expire(expire));

    rx_eom_deser u_deser (
        .clk(clk), .rst(rst), .clear(start_evt), .en(state == ST_RECV),
        .bit_stb(bit_stb), .bit_data(bit_data),
        .byte_vld(byte_vld), .byte_val(byte_val));

    rx_eom_end_det u_end (
        .clk(clk), .rst(rst), .clear(start_evt), .chr_mode(cfg.chr_mode),
        .offset(cfg.offset), .term(cfg.term), .esc(cfg.esc),
        .byte_vld(byte_vld), .byte_val(byte_val), .eom(eom));

    always_ff @(posedge clk) begin
        if (rst)                      state <= ST_OFF;
        else if (host_rx_en)          state <= ST_WAIT;
        else if (start_evt)           state <= ST_RECV;
        else if (tmo_evt || eom_evt)  state <= ST_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst)             sts <= STS_NONE;
        else if (eom_evt)    sts <= STS_DONE;
        else if (tmo_evt)    sts <= STS_TMO;
        else if (status_clr) sts <= STS_NONE;
    end

    assign rx_pwr_en = (state != ST_OFF);
    assign status    = sts;

    // R2: re-arm powers the receiver on the next cycle
    assert_rearm_pwr_R2: assert property (@(posedge clk) disable iff (rst)
        host_rx_en |=> rx_pwr_en);
    // R7: power falls only with a reported reason
    assert_fall_reason_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_pwr_en) |-> (status != STS_NONE));
    // R8: a start strobe while waiting always enters receive
    assert_som_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && som && !host_rx_en) |=> (state == ST_RECV));
    // R9: a held code only leaves through a clear
    assert_sts_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (status != STS_NONE && !status_clr) |=> (status != STS_NONE));
endmodule

// File: tb/rx_eom_detect_tb.sv
module rx_eom_detect_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       host_rx_en = 1'b0, status_clr = 1'b0, som = 1'b0;
    logic       bit_stb = 1'b0, bit_data = 1'b0;
    logic       rx_pwr_en;
    logic [1:0] status;
    int nchk = 0, nbad = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    rx_eom_detect u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .host_rx_en(host_rx_en), .status_clr(status_clr),
        .som(som), .bit_stb(bit_stb), .bit_data(bit_data),
        .rx_pwr_en(rx_pwr_en), .status(status));

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
        @(negedge clk); cfg_we = 1'b0;
    endtask
    task automatic rearm();
        @(negedge clk); host_rx_en = 1'b1;
        @(negedge clk); host_rx_en = 1'b0;
    endtask
    task automatic clr();
        @(negedge clk); status_clr = 1'b1;
        @(negedge clk); status_clr = 1'b0;
    endtask
    task automatic start();
        @(negedge clk); som = 1'b1;
        @(negedge clk); som = 1'b0;
    endtask
    task automatic send_bit(input logic b);
        @(negedge clk); bit_stb = 1'b1; bit_data = b;
        @(negedge clk); bit_stb = 1'b0;
    endtask
    task automatic send_byte(input int b);
        for (int k = 7; k >= 0; k--) send_bit(1'(b >> k));
    endtask
    task automatic set_tmo(input int t);
        wr(4, t & 255); wr(5, (t >> 8) & 255);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            nbad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pwr after reset", rx_pwr_en, 0);
        check("R1 status after reset", status, 0);

        // R1, R5, R6: reset terminator/escape in character mode
        wr(0, 1); set_tmo(1000); rearm();
        check("R2 pwr after rearm", rx_pwr_en, 1);
        start();
        send_byte(8'h80); send_byte(8'hFE);
        check("R6 escaped terminator literal", rx_pwr_en, 1);
        send_byte(8'h80); send_byte(8'h80);
        check("R6 escaped escape literal", rx_pwr_en, 1);
        send_byte(8'hFE);
        check("R1 R5 reset terminator ends", rx_pwr_en, 0);
        check("R5 status done", status, 1);
        repeat (5) @(negedge clk);
        check("R9 status held", status, 1);
        clr();
        check("R9 status cleared", status, 0);

        // R3: MSB first and bits before SOM ignored
        wr(2, 8'h0F); rearm();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        start();
        send_byte(8'hF0);
        check("R3 reversed byte not terminator", rx_pwr_en, 1);
        for (int k = 7; k >= 1; k--) send_bit(1'((8'h0F) >> k));
        check("R3 no end before 8th bit", rx_pwr_en, 1);
        send_bit(1'b1);
        check("R3 MSB-first terminator ends", rx_pwr_en, 0);
        clr();

        // R2: writes during a run wait for the next re-arm
        wr(2, 8'hFE); rearm(); start();
        wr(2, 8'h11);
        send_byte(8'h11);
        check("R2 mid-run write not used", rx_pwr_en, 1);
        send_byte(8'hFE);
        check("R2 old terminator still used", rx_pwr_en, 0);
        clr(); rearm(); start();
        send_byte(8'h11);
        check("R2 new terminator after rearm", rx_pwr_en, 0);
        clr();

        // R4: length mode sweep over offsets and lengths
        wr(0, 0);
        for (int off = 0; off < 4; off++) begin
            for (int len = 0; len < 5; len++) begin
                wr(1, off); rearm(); start();
                for (int i = 0; i <= off + len; i++) begin
                    send_byte((i == off) ? len : ((i * 37 + 5) & 255));
                    check($sformatf("R4 off=%0d len=%0d byte=%0d", off, len, i),
                          rx_pwr_en, (i < off + len) ? 1 : 0);
                end
                check("R4 status done", status, 1);
                clr();
            end
        end

        // R7: idle timeout sweep, including a zero limit
        for (int t = 0; t < 7; t++) begin
            int n;
            set_tmo(t); rearm();
            n = 0;
            while (rx_pwr_en && n < 100) begin
                n++;
                @(negedge clk);
            end
            check($sformatf("R7 high cycles t=%0d", t), n, (t < 1) ? 1 : t);
            check("R7 status timeout", status, 2);
            clr();
        end

        // R8: SOM on the expiry edge beats the timeout
        set_tmo(5); rearm();
        repeat (4) @(negedge clk);
        som = 1'b1; @(negedge clk); som = 1'b0;
        check("R8 pwr kept on collision", rx_pwr_en, 1);
        check("R8 no timeout on collision", status, 0);
        rearm();
        repeat (5) @(negedge clk);
        check("R8 late SOM after expiry pwr", rx_pwr_en, 0);
        som = 1'b1; @(negedge clk); som = 1'b0;
        check("R8 late SOM timeout kept", status, 2);
        clr();

        // R10: unused addresses leave the configuration intact
        wr(0, 1); wr(2, 8'h3C); set_tmo(3);
        wr(6, 8'hFF); wr(7, 8'h00);
        rearm();
        repeat (3) @(negedge clk);
        check("R10 limit unchanged by addr 6/7", rx_pwr_en, 0);
        clr(); set_tmo(1000); rearm(); start();
        send_byte(8'h3C);
        check("R10 terminator unchanged by addr 6/7", rx_pwr_en, 0);

        // R9: clear on the completing edge loses
        rearm(); start();
        for (int k = 7; k >= 1; k--) send_bit(1'((8'h3C) >> k));
        @(negedge clk); bit_stb = 1'b1; bit_data = 1'b0; status_clr = 1'b1;
        @(negedge clk); bit_stb = 1'b0; status_clr = 1'b0;
        check("R9 completion beats clear", status, 1);
        check("R9 pwr off at completion", rx_pwr_en, 0);

        ended = 1'b1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule